// File: doc/BRIEF.md
# Burst Address Counter, Multi-Port

This block produces the memory address for each port of a multi-port memory. Every port has its own registered counter, and the counter runs on that port's own clock. Three active-low controls are sampled on each rising edge of the port clock:

- a clear control sets the counter to zero;
- a load strobe copies the externally supplied address into it;
- a step enable advances it by one.

When none of the three is asserted, the counter keeps its value. The counter covers the whole array and wraps from the last location back to zero, so a burst can run without a break.

The address seen by the memory is always the registered counter value. It changes only after a rising clock edge. A user starts a burst by strobing in a start address. The user then holds the step enable low for as many words as the burst needs and releases it to stop. The latency mode of the memory does not affect this block, so bursting works the same way behind flow-through and pipelined outputs.

Top module: `burst_addr_gen`

## Requirements
- R1: While a port's asynchronous reset `rst_ni[p]` is low, that port's address output is 0.
- R2: When `cntrst_ni[p]` is low at a rising edge of `clk_i[p]`, the counter becomes 0 after that edge. This holds whatever the load strobe and step enable are doing.
- R3: When `cntrst_ni[p]` is high and `ads_ni[p]` is low at an edge, the counter takes the value of `ext_addr_i[p*ADDR_W +: ADDR_W]`. This holds whatever the step enable is doing.
- R4: When only `cnten_ni[p]` is low at an edge, the counter increases by exactly one.
- R5: Stepping from the highest address (2^ADDR_W−1, which is 16383 by default) gives address 0.
- R6: When all three controls are high, the counter keeps its value.
- R7: The address output is registered. A change on the control or address inputs between clock edges leaves `addr_o` unchanged.
- R8: Ports are independent. Activity on one port never changes another port's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | NUM_PORTS | Per-port clock, rising edge active |
| rst_ni | input | NUM_PORTS | Per-port asynchronous reset, active low |
| ads_ni | input | NUM_PORTS | Load strobe, active low |
| cnten_ni | input | NUM_PORTS | Step enable, active low |
| cntrst_ni | input | NUM_PORTS | Synchronous counter clear, active low |
| ext_addr_i | input | NUM_PORTS*ADDR_W | External address buses; port p uses bits [p*ADDR_W +: ADDR_W] |
| addr_o | output | NUM_PORTS*ADDR_W | Registered counter addresses; port p uses bits [p*ADDR_W +: ADDR_W] |

## Verification
The bench asserts the controls in combination to test their priority:

- The clear control is asserted together with the load strobe and the step enable. A design with the priority inverted would load the bus or step instead of returning to zero.
- The load strobe is asserted together with the step enable. A design with the wrong order would add one to the loaded value.

Bursts are started a few words below the top of the array. This catches counters that saturate at the top, or that carry into a bit beyond the address width, instead of wrapping to zero.

Inputs are changed in the middle of a cycle, and the address is checked before the next edge. This exposes any path from the inputs to the address that bypasses the register. One port is held idle while the other is driven, which exposes crossed port slices.

// File: rtl/bac_pkg.sv
package bac_pkg;

  localparam int unsigned BAC_ADDR_W_DEF = 14;
  localparam int unsigned BAC_PORTS_DEF  = 2;

  // Action taken by a counter at the next clock edge.
  typedef enum logic [1:0] {
    BAC_HOLD  = 2'd0,
    BAC_STEP  = 2'd1,
    BAC_LOAD  = 2'd2,
    BAC_CLEAR = 2'd3
  } bac_cmd_e;

  // Priority: clear over load over step; all controls active low.
  function automatic bac_cmd_e bac_pick(input logic clr_n, input logic ld_n,
                                        input logic stp_n);
    bac_cmd_e c;
    if (!clr_n)      c = BAC_CLEAR;
    else if (!ld_n)  c = BAC_LOAD;
    else if (!stp_n) c = BAC_STEP;
    else             c = BAC_HOLD;
    return c;
  endfunction

endpackage

// File: rtl/bac_ctl_decode.sv
module bac_ctl_decode
  import bac_pkg::*;
(
  input  logic     clr_ni,
  input  logic     ld_ni,
  input  logic     stp_ni,
  output bac_cmd_e cmd_o,
  output logic     stp_evt_o
);

  always_comb begin
    cmd_o = bac_pick(clr_ni, ld_ni, stp_ni);
  end

  assign stp_evt_o = (cmd_o == BAC_STEP);

endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int unsigned ADDR_W = BAC_ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bac_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              wrap_evt_o
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  // Modulo-2^ADDR_W increment; the carry out is simply dropped.
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;

  always_comb begin
    unique case (cmd_i)
      BAC_CLEAR: cnt_d = '0;
      BAC_LOAD:  cnt_d = load_val_i;
      BAC_STEP:  cnt_d = addr_step(cnt_q);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign wrap_evt_o = (cmd_i == BAC_STEP) && (cnt_q == TOP_ADDR);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int unsigned NUM_PORTS = BAC_PORTS_DEF,
  parameter int unsigned ADDR_W    = BAC_ADDR_W_DEF
) (
  input  logic [NUM_PORTS-1:0]        clk_i,
  input  logic [NUM_PORTS-1:0]        rst_ni,
  input  logic [NUM_PORTS-1:0]        ads_ni,
  input  logic [NUM_PORTS-1:0]        cnten_ni,
  input  logic [NUM_PORTS-1:0]        cntrst_ni,
  input  logic [NUM_PORTS*ADDR_W-1:0] ext_addr_i,
  output logic [NUM_PORTS*ADDR_W-1:0] addr_o
);

  // Internal events, named for the bound checker.
  logic [NUM_PORTS-1:0] step_evt;
  logic [NUM_PORTS-1:0] wrap_evt;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    bac_cmd_e cmd;

    bac_ctl_decode u_dec (
      .clr_ni    (cntrst_ni[g]),
      .ld_ni     (ads_ni[g]),
      .stp_ni    (cnten_ni[g]),
      .cmd_o     (cmd),
      .stp_evt_o (step_evt[g])
    );

    bac_counter #(.ADDR_W(ADDR_W)) u_cnt (
      .clk_i      (clk_i[g]),
      .rst_ni     (rst_ni[g]),
      .cmd_i      (cmd),
      .load_val_i (ext_addr_i[g*ADDR_W +: ADDR_W]),
      .cnt_o      (addr_o[g*ADDR_W +: ADDR_W]),
      .wrap_evt_o (wrap_evt[g])
    );
  end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 14
) (
  input logic [NUM_PORTS-1:0]        clk_i,
  input logic [NUM_PORTS-1:0]        rst_ni,
  input logic [NUM_PORTS-1:0]        ads_ni,
  input logic [NUM_PORTS-1:0]        cnten_ni,
  input logic [NUM_PORTS-1:0]        cntrst_ni,
  input logic [NUM_PORTS*ADDR_W-1:0] ext_addr_i,
  input logic [NUM_PORTS*ADDR_W-1:0] addr_o,
  input logic [NUM_PORTS-1:0]        step_evt,
  input logic [NUM_PORTS-1:0]        wrap_evt
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] e;
    assign a = addr_o[g*ADDR_W +: ADDR_W];
    assign e = ext_addr_i[g*ADDR_W +: ADDR_W];

    AST_CLEAR_WINS: assert property (@(posedge clk_i[g]) disable iff (!rst_ni[g])
      !cntrst_ni[g] |=> a == '0); // R2
    AST_LOAD_OVER_STEP: assert property (@(posedge clk_i[g]) disable iff (!rst_ni[g])
      (cntrst_ni[g] && !ads_ni[g]) |=> a == $past(e)); // R3
    AST_STEP_BY_ONE: assert property (@(posedge clk_i[g]) disable iff (!rst_ni[g])
      step_evt[g] |=> a == $past(a) + 1'b1); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk_i[g]) disable iff (!rst_ni[g])
      wrap_evt[g] |=> a == '0); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk_i[g]) disable iff (!rst_ni[g])
      (cntrst_ni[g] && ads_ni[g] && cnten_ni[g]) |=> $stable(a)); // R6
  end

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ads_ni     (ads_ni),
  .cnten_ni   (cnten_ni),
  .cntrst_ni  (cntrst_ni),
  .ext_addr_i (ext_addr_i),
  .addr_o     (addr_o),
  .step_evt   (step_evt),
  .wrap_evt   (wrap_evt)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int NP = 2;
  localparam int AW = 14;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] ads_n = '1, cnten_n = '1, cntrst_n = '1;
  logic [NP*AW-1:0] ext = '0;
  logic [NP*AW-1:0] addr;

  int vectors = 0, fails = 0;
  int mdl [NP];
  string tag [NP];
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.NUM_PORTS(NP), .ADDR_W(AW)) dut (
    .clk_i({NP{clk}}), .rst_ni({NP{rst_n}}), .ads_ni(ads_n), .cnten_ni(cnten_n),
    .cntrst_ni(cntrst_n), .ext_addr_i(ext), .addr_o(addr));

  initial begin
    for (int p = 0; p < NP; p++) begin mdl[p] = 0; tag[p] = "R1"; end
  end

  // Behavioural reference, one step per rising edge.
  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (!rst_n) begin mdl[p] = 0; tag[p] = "R1"; end
      else if (!cntrst_n[p]) begin mdl[p] = 0; tag[p] = "R2"; end
      else if (!ads_n[p]) begin mdl[p] = int'(ext[p*AW +: AW]); tag[p] = "R3"; end
      else if (!cnten_n[p]) begin
        tag[p] = (mdl[p] == SPAN-1) ? "R5" : "R4";
        mdl[p] = (mdl[p] + 1) % SPAN;
      end else begin
        tag[p] = (cntrst_n[1-p] && ads_n[1-p] && cnten_n[1-p]) ? "R6" : "R8";
      end
    end
  end

  task automatic chk(input int p, input string t);
    int got;
    got = int'(addr[p*AW +: AW]);
    vectors++;
    if (got != mdl[p]) begin
      fails++;
      $display("FAIL %s port%0d addr actual=%0d expected=%0d at %0t", t, p, got, mdl[p], $time);
    end
  endtask

  always @(negedge clk) if (!done) for (int p = 0; p < NP; p++) chk(p, tag[p]);

  // Drive one cycle: {clr,ld,stp} active low per port, then re-check mid-cycle (R7).
  task automatic cyc(input logic [2:0] c0, input int a0, input logic [2:0] c1, input int a1);
    @(negedge clk);
    #1;
    {cntrst_n[0], ads_n[0], cnten_n[0]} = c0;
    {cntrst_n[1], ads_n[1], cnten_n[1]} = c1;
    ext[0 +: AW] = AW'(a0);
    ext[AW +: AW] = AW'(a1);
    #1;
    for (int p = 0; p < NP; p++) chk(p, "R7");
  endtask

  localparam logic [2:0] IDLE = 3'b111, STEP = 3'b110, LOAD = 3'b101,
                         LDST = 3'b100, CLR = 3'b011, ALL = 3'b000;

  initial begin
    repeat (3) @(negedge clk);  // R1 checked while reset is held
    #1 rst_n = 1'b1;
    cyc(LOAD, 16'h1234, IDLE, 0);                       // R3, R8
    for (int i = 0; i < 6; i++) cyc(STEP, 0, IDLE, 0);  // R4, R8
    cyc(IDLE, 0, LOAD, SPAN-3);                         // R6, R3
    for (int i = 0; i < 6; i++) cyc(IDLE, 0, STEP, 0);  // R5 wrap
    cyc(LDST, 100, ALL, 555);                           // R3 over step, R2 over all
    cyc(IDLE, 0, IDLE, 0);
    cyc(CLR, 0, STEP, 0);                               // R2
    cyc(LOAD, SPAN-1, LOAD, SPAN-1);
    cyc(STEP, 0, LDST, 7);                              // R5, R3
    cyc(IDLE, 0, IDLE, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] r0, r1;
      r0 = 3'($urandom);
      r1 = 3'($urandom);
      if ($urandom % 4 != 0) r0[2] = 1'b1;
      if ($urandom % 4 != 0) r1[2] = 1'b1;
      if ($urandom % 3 != 0) r0[1] = 1'b1;
      if ($urandom % 3 != 0) r1[1] = 1'b1;
      cyc(r0, (SPAN - 8) + int'($urandom % 16), r1, int'($urandom % SPAN));
    end
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule